// File: doc/BRIEF.md
# Modulo Circular-Buffer Address Generator

This block forms the effective address for a register-indirect memory access made through one of several pointer registers. It can also fold that address back into a circular buffer. Each access arrives on one cycle, qualified by `en`. The access carries:
- the current pointer value and the index of that pointer;
- a signed step, which is a modify amount or an offset;
- a mode;
- a flag that marks a write.

Buffer bounds come from a configuration: an inclusive lower address, an inclusive upper address, the index of the pointer that owns the buffer, and a modulo enable.

The step is added to the pointer. When modulo correction applies, a positive or zero step whose sum lands above the upper bound has the buffer length subtracted, and a negative step whose sum lands below the lower bound has the length added. The compares are inequalities, so a step that goes well past a bound still lands at the correct place inside the buffer. The buffer length is upper − lower + 1, and the step magnitude must not exceed that length.

Pre-modify and post-modify accesses return the corrected pointer through a write-back port to the register file. Offset accesses use the corrected address but leave the pointer unchanged. A separate bit-reverse indication has priority over modulo correction on writes only, and turns the correction off for them. All outputs are registered and appear one cycle after the access. The buffer must not straddle address 0 or the top of the address space.

Top module: `modaddr_gen`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `ea_valid`, `wb_en`, `ea_out`, `wb_val` and `wb_idx` are all zero.
- R2: `ea_valid` is high exactly one cycle after a cycle with `en` high, and low after a cycle with `en` low.
- R3: When correction applies and the step is zero or positive, a sum greater than `buf_hi` is reduced by (`buf_hi` − `buf_lo` + 1). This includes sums that pass the bound by more than one.
- R4: When correction applies and the step is negative, a sum less than `buf_lo` is increased by (`buf_hi` − `buf_lo` + 1). This includes sums that pass the bound by more than one.
- R5: Correction applies only when `mod_on` is 1 and `ptr_idx` equals `mod_ptr`. A sum inside [`buf_lo`, `buf_hi`] is never changed.
- R6: Post-modify (`mode` = 2'b00): `ea_out` is the old pointer, and `wb_val` is the corrected pointer + step, with `wb_en` high.
- R7: Pre-modify (`mode` = 2'b01): `ea_out` and `wb_val` both equal the corrected pointer + step, with `wb_en` high.
- R8: Offset (`mode` = 2'b10): `ea_out` is the corrected pointer + step, and `wb_en` stays low.
- R9: When `brev_on` is 1, correction is suppressed for accesses with `is_write` = 1. It still applies to accesses with `is_write` = 0.
- R10: When `wb_en` is high, `wb_idx` equals the `ptr_idx` of the access.
- R11: Plain (`mode` = 2'b11): `ea_out` is the pointer unchanged and `wb_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Access valid this cycle |
| ptr_idx | input | PW | Index of the pointer used by the access |
| ptr_val | input | AW | Current pointer contents |
| step | input | AW | Signed modify amount or offset (two's complement) |
| mode | input | 2 | 00 post-modify, 01 pre-modify, 10 offset, 11 plain |
| is_write | input | 1 | Access is a data write |
| brev_on | input | 1 | Bit-reverse addressing active on the write path |
| mod_on | input | 1 | Modulo buffer enabled |
| mod_ptr | input | PW | Pointer index that owns the buffer |
| buf_lo | input | AW | Inclusive lower buffer address |
| buf_hi | input | AW | Inclusive upper buffer address |
| ea_valid | output | 1 | Effective address valid |
| ea_out | output | AW | Effective address |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_idx | output | PW | Pointer index to write back |
| wb_val | output | AW | Value to write back |

## Verification
A fault in the wrap path appears one cycle after the access. It shows up as an address outside the buffer on a pre-modify or offset access, or as a write-back value outside the buffer on a post-modify access. A fault in the qualifier shows up on the same cycle as a wrap that should not happen, or a missing wrap, when the pointer index, the write flag or the bit-reverse flag change. Random accesses use overshoots up to the full buffer length in both directions. Directed cases cover sums exactly on each bound, sums just past each bound, and a write next to a read with bit-reverse active.

// File: rtl/modaddr_pkg.sv
package modaddr_pkg;
  typedef enum logic [1:0] {
    AM_POST  = 2'b00,
    AM_PRE   = 2'b01,
    AM_OFFS  = 2'b10,
    AM_PLAIN = 2'b11
  } amode_t;
endpackage

// File: rtl/modaddr_qual.sv
// Decides whether modulo correction applies to the current access.
module modaddr_qual #(
  parameter int PW = 4
) (
  input  logic          mod_on,
  input  logic [PW-1:0] mod_ptr,
  input  logic [PW-1:0] ptr_idx,
  input  logic          is_write,
  input  logic          brev_on,
  output logic          apply
);
  logic owner;
  logic brev_block;
  always_comb begin
    owner      = (ptr_idx == mod_ptr);
    brev_block = is_write & brev_on;   // bit-reverse wins on writes only
    apply      = mod_on & owner & ~brev_block;
  end
endmodule

// File: rtl/modaddr_wrap.sv
// Adds the step and folds the sum back into [lo, hi] using inequality compares.
module modaddr_wrap #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          apply,
  output logic [AW-1:0] res
);
  logic [AW-1:0] sum;
  logic [AW-1:0] span;
  logic          down;
  always_comb begin
    sum  = base + step;
    span = hi - lo + 1'b1;
    down = step[AW-1];
    res  = sum;
    if (apply) begin
      if (!down && (sum > hi))
        res = sum - span;
      else if (down && (sum < lo))
        res = sum + span;
    end
  end
endmodule

// File: rtl/modaddr_gen.sv
module modaddr_gen
  import modaddr_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NPTR = 16,
  localparam int PW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] ptr_idx,
  input  logic [AW-1:0] ptr_val,
  input  logic [AW-1:0] step,
  input  logic [1:0]    mode,
  input  logic          is_write,
  input  logic          brev_on,
  input  logic          mod_on,
  input  logic [PW-1:0] mod_ptr,
  input  logic [AW-1:0] buf_lo,
  input  logic [AW-1:0] buf_hi,
  output logic          ea_valid,
  output logic [AW-1:0] ea_out,
  output logic          wb_en,
  output logic [PW-1:0] wb_idx,
  output logic [AW-1:0] wb_val
);
  logic          apply;
  logic [AW-1:0] fixed;
  logic [AW-1:0] ea_nxt;
  logic          wb_nxt;
  amode_t        am;

  modaddr_qual #(.PW(PW)) u_qual (
    .mod_on   (mod_on),
    .mod_ptr  (mod_ptr),
    .ptr_idx  (ptr_idx),
    .is_write (is_write),
    .brev_on  (brev_on),
    .apply    (apply)
  );

  modaddr_wrap #(.AW(AW)) u_wrap (
    .base  (ptr_val),
    .step  (step),
    .lo    (buf_lo),
    .hi    (buf_hi),
    .apply (apply),
    .res   (fixed)
  );

  always_comb begin
    am = amode_t'(mode);
    unique case (am)
      AM_POST:  begin ea_nxt = ptr_val; wb_nxt = 1'b1; end
      AM_PRE:   begin ea_nxt = fixed;   wb_nxt = 1'b1; end
      AM_OFFS:  begin ea_nxt = fixed;   wb_nxt = 1'b0; end
      default:  begin ea_nxt = ptr_val; wb_nxt = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid <= 1'b0;
      ea_out   <= '0;
      wb_en    <= 1'b0;
      wb_idx   <= '0;
      wb_val   <= '0;
    end else begin
      ea_valid <= en;
      wb_en    <= en & wb_nxt;
      if (en) begin
        ea_out <= ea_nxt;
        wb_idx <= ptr_idx;
        wb_val <= fixed;
      end
    end
  end
endmodule

// File: rtl/modaddr_gen_chk.sv
module modaddr_gen_chk #(
  parameter int AW = 16,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [PW-1:0] ptr_idx,
  input logic [AW-1:0] ptr_val,
  input logic [AW-1:0] step,
  input logic [1:0]    mode,
  input logic          is_write,
  input logic          brev_on,
  input logic          mod_on,
  input logic [PW-1:0] mod_ptr,
  input logic [AW-1:0] buf_lo,
  input logic [AW-1:0] buf_hi,
  input logic          ea_valid,
  input logic [AW-1:0] ea_out,
  input logic          wb_en,
  input logic [PW-1:0] wb_idx,
  input logic [AW-1:0] wb_val
);
  logic [AW-1:0] mag;
  logic [AW-1:0] span;
  logic          inbuf_case;
  always_comb begin
    mag  = step[AW-1] ? (~step + 1'b1) : step;
    span = buf_hi - buf_lo + 1'b1;
    inbuf_case = en && mod_on && (ptr_idx == mod_ptr) && !is_write &&
                 (buf_hi >= buf_lo) && (ptr_val >= buf_lo) && (ptr_val <= buf_hi) &&
                 (mag <= span) && (mode == 2'b01);
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!ea_valid && !wb_en));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    en |=> ea_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!ea_valid && !wb_en));

  assert_wrap_inside_R3: assert property (@(posedge clk) disable iff (rst)
    inbuf_case |=> (ea_out >= $past(buf_lo) && ea_out <= $past(buf_hi)));

  assert_post_ea_R6: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b00) |=> (ea_out == $past(ptr_val) && wb_en));

  assert_pre_same_R7: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b01) |=> (wb_en && wb_val == ea_out));

  assert_offs_nowb_R8: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b10) |=> !wb_en);

  assert_wb_idx_R10: assert property (@(posedge clk) disable iff (rst)
    (en && mode[1] == 1'b0) |=> (wb_idx == $past(ptr_idx)));

  assert_plain_R11: assert property (@(posedge clk) disable iff (rst)
    (en && mode == 2'b11) |=> (!wb_en && ea_out == $past(ptr_val)));
endmodule

bind modaddr_gen modaddr_gen_chk #(.AW(AW), .PW(PW)) u_chk (.*);

// File: tb/modaddr_gen_test.sv
module modaddr_gen_test;
  localparam int AW = 16;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [PW-1:0] ptr_idx = '0;
  logic [AW-1:0] ptr_val = '0;
  logic [AW-1:0] step = '0;
  logic [1:0]    mode = 2'b00;
  logic          is_write = 1'b0;
  logic          brev_on = 1'b0;
  logic          mod_on = 1'b0;
  logic [PW-1:0] mod_ptr = '0;
  logic [AW-1:0] buf_lo = '0;
  logic [AW-1:0] buf_hi = '0;
  logic          ea_valid;
  logic [AW-1:0] ea_out;
  logic          wb_en;
  logic [PW-1:0] wb_idx;
  logic [AW-1:0] wb_val;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modaddr_gen #(.AW(AW), .NPTR(16)) uut (.*);

  function automatic logic [AW-1:0] fold(input logic [AW-1:0] p, input logic [AW-1:0] s,
                                         input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                                         input logic ap);
    logic [AW-1:0] t;
    t = p + s;
    if (ap && !s[AW-1] && t > hi) t = t - (hi - lo + 1);
    else if (ap && s[AW-1] && t < lo) t = t + (hi - lo + 1);
    return t;
  endfunction

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one access, then sample one cycle later away from the edge.
  task automatic access(input string req, input logic [PW-1:0] idx, input logic [AW-1:0] p,
                        input logic [AW-1:0] s, input logic [1:0] m, input logic w);
    logic ap;
    logic [AW-1:0] f;
    logic [AW-1:0] e_ea;
    logic e_wb;
    @(negedge clk);
    en = 1'b1; ptr_idx = idx; ptr_val = p; step = s; mode = m; is_write = w;
    ap = mod_on && (idx == mod_ptr) && !(w && brev_on);
    f = fold(p, s, buf_lo, buf_hi, ap);
    e_ea = (m == 2'b01 || m == 2'b10) ? f : p;
    e_wb = (m[1] == 1'b0);
    @(posedge clk); #1;
    chk({req, " valid R2"}, AW'(ea_valid), AW'(1));
    chk({req, " ea"}, ea_out, e_ea);
    chk({req, " wb_en"}, AW'(wb_en), AW'(e_wb));
    if (e_wb) begin
      chk({req, " wb_val"}, wb_val, f);
      chk({req, " wb_idx R10"}, AW'(wb_idx), AW'(idx));
    end
    en = 1'b0;
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1 ea_valid", AW'(ea_valid), AW'(0));
    chk("R1 wb_en", AW'(wb_en), AW'(0));
    chk("R1 ea_out", ea_out, '0);
    chk("R1 wb_val", wb_val, '0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R2 idle", AW'(ea_valid), AW'(0));

    mod_on = 1'b1; mod_ptr = 4'd3; buf_lo = 16'h1000; buf_hi = 16'h100F;
    // R3 exact-boundary cases and overshoot
    access("R3 on bound",   4'd3, 16'h100E, 16'd1, 2'b01, 1'b0);
    chk("R3 on bound val", ea_out, 16'h100F);
    access("R3 just past",  4'd3, 16'h100F, 16'd1, 2'b01, 1'b0);
    chk("R3 just past val", ea_out, 16'h1000);
    access("R3 overshoot",  4'd3, 16'h100C, 16'd10, 2'b01, 1'b0);
    chk("R3 overshoot val", ea_out, 16'h1006);
    // R4
    access("R4 just below", 4'd3, 16'h1000, 16'hFFFE, 2'b00, 1'b0);
    chk("R4 wb val", wb_val, 16'h100E);
    chk("R6 post ea old", ea_out, 16'h1000);
    access("R4 on bound",   4'd3, 16'h1002, 16'hFFFE, 2'b01, 1'b0);
    chk("R4 on bound val", ea_out, 16'h1000);
    // R5 other pointer / modulo off
    access("R5 other ptr", 4'd2, 16'h100F, 16'd4, 2'b01, 1'b0);
    chk("R5 other ptr val", ea_out, 16'h1013);
    mod_on = 1'b0;
    access("R5 mod off", 4'd3, 16'h100F, 16'd4, 2'b01, 1'b0);
    chk("R5 mod off val", ea_out, 16'h1013);
    mod_on = 1'b1;
    // R8 offset
    access("R8 offset", 4'd3, 16'h100D, 16'd6, 2'b10, 1'b0);
    chk("R8 offset val", ea_out, 16'h1003);
    chk("R8 no wb", AW'(wb_en), AW'(0));
    // R9 bit-reverse priority
    brev_on = 1'b1;
    access("R9 write", 4'd3, 16'h100F, 16'd2, 2'b01, 1'b1);
    chk("R9 write unwrapped", ea_out, 16'h1011);
    access("R9 read", 4'd3, 16'h100F, 16'd2, 2'b01, 1'b0);
    chk("R9 read wrapped", ea_out, 16'h1001);
    brev_on = 1'b0;
    // R11 plain
    access("R11 plain", 4'd3, 16'h100F, 16'd2, 2'b11, 1'b0);
    chk("R11 ea", ea_out, 16'h100F);

    // Random accesses (R3 R4 R5 R6 R7 R8 R9 R10 R11)
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] lo, len, p, mg, s;
      lo  = 16'h0400 + AW'($urandom_range(0, 16'h8000));
      len = AW'($urandom_range(1, 300));
      buf_lo = lo; buf_hi = lo + len - 1;
      mod_on = ($urandom_range(0, 7) != 0);
      mod_ptr = PW'($urandom_range(0, 3));
      brev_on = $urandom_range(0, 1);
      p  = lo + AW'($urandom_range(0, len - 1));
      mg = AW'($urandom_range(0, len));
      s  = $urandom_range(0, 1) ? (~mg + 1'b1) : mg;
      access("Rrand", PW'($urandom_range(0, 3)), p, s, 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)));
    end

    @(negedge clk); en = 1'b0;
    @(posedge clk); #1;
    chk("R2 idle after", AW'(ea_valid), AW'(0));
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule